// File: doc/BRIEF.md
# Byte SEC-DED Error-Correcting Code Unit

This block guards a data byte held in a memory with five check bits. On the write side, an encoder turns the byte into four Hamming check bits and one overall parity bit. On the read side, a decoder takes the byte and its five check bits as read back. It rebuilds the codeword and forms a four-bit syndrome. It then repairs a single flipped bit and reports whether a single or a double error was seen.

The Hamming check bits sit at the power-of-two positions of a 12-position codeword. The data bits fill the remaining positions. The overall parity bit lies outside the codeword and covers all twelve positions. This is what lets the decoder tell a correctable single error apart from an uncorrectable double error.

Both paths are combinational logic. A build-time switch either passes the results straight through or registers them once.

Top module: `sec_ded_byte`

## Requirements
- R1: Codeword positions run 1 to 12. Data bit k (k = 0..7) sits at positions 3, 5, 6, 7, 9, 10, 11, 12 in that order, and Hamming check bit i (i = 0..3, output bit i) sits at position 2^i. Each check bit i gives even parity over all positions whose index has bit i set.
- R2: Check output bit 4 gives even parity over all 13 stored bits: the data byte plus check bits 0 to 4.
- R3: A stored word with no error yields the stored byte on the data output, with both error flags low.
- R4: A single flipped bit among the data byte or check bits 0 to 3 is repaired. The original byte appears on the output, the single-error flag is high and the double-error flag is low.
- R5: When only check bit 4 is flipped (zero syndrome, overall parity mismatch), the single-error flag is high, the double-error flag is low and the byte passes through unchanged.
- R6: Any two flipped bits among the 13 stored bits raise the double-error flag and leave the single-error flag low. The received byte passes through uncorrected.
- R7: A syndrome above 12 together with an overall parity mismatch raises the double-error flag, leaves the single-error flag low and passes the byte through uncorrected.
- R8: The single-error and double-error flags are never high together.
- R9: With REG_OUT = 1, every output reflects the inputs present at the previous rising clock edge, and reset (active low, asynchronous) clears all outputs to zero. With REG_OUT = 0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| enc_data_i | input | 8 | Byte to encode |
| enc_check_o | output | 5 | Check bits for enc_data_i (bits 3:0 Hamming, bit 4 overall) |
| dec_data_i | input | 8 | Byte as read from storage |
| dec_check_i | input | 5 | Check bits as read from storage |
| dec_data_o | output | 8 | Repaired byte |
| dec_sef_o | output | 1 | Single error seen (and repaired) |
| dec_def_o | output | 1 | Double or uncorrectable error seen |

## Verification
The bench builds two copies, both with DATA_W = 8. One has REG_OUT = 1 and the other REG_OUT = 0, and both are driven by the same stimulus. The registered copy exposes the reset value and the one-cycle delay. Comparing it with the combinational copy during a changing input shows that the delay is exactly one edge. The 8-bit width keeps a full sweep of all 256 bytes through the encoder within reach. It also allows every single-bit flip and every pair of flips across all 13 stored bits, for several bytes.

// File: rtl/secded_pkg.sv
package secded_pkg;

    // number of Hamming check bits needed for dw data bits
    function automatic int hm_par_bits(int dw);
        int p;
        p = 0;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    // codeword position (1-based) holding data bit k
    function automatic int data_pos(int k);
        int cnt;
        int res;
        cnt = -1;
        res = 0;
        for (int p = 1; p < 256; p++) begin
            if (res == 0 && (p & (p - 1)) != 0) begin
                cnt++;
                if (cnt == k) res = p;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/sd_encoder.sv
module sd_encoder
    import secded_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int PAR_W = hm_par_bits(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [PAR_W:0]    chk_o
);
    localparam int CW_W = DATA_W + PAR_W;

    logic [CW_W:1] cw;

    always_comb begin
        cw = '0;
        for (int k = 0; k < DATA_W; k++) cw[data_pos(k)] = data_i[k];
        chk_o = '0;
        for (int i = 0; i < PAR_W; i++) begin
            for (int p = 1; p <= CW_W; p++) begin
                if (((p >> i) & 1) == 1) chk_o[i] = chk_o[i] ^ cw[p];
            end
        end
        for (int i = 0; i < PAR_W; i++) cw[1 << i] = chk_o[i];
        chk_o[PAR_W] = ^cw;
    end
endmodule

// File: rtl/sd_decoder.sv
module sd_decoder
    import secded_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int PAR_W = hm_par_bits(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [PAR_W:0]    chk_i,
    output logic [DATA_W-1:0] data_o,
    output logic              sef_o,
    output logic              def_o
);
    localparam int CW_W = DATA_W + PAR_W;

    logic [CW_W:1]    cw;
    logic [CW_W:1]    cw_fix;
    logic [PAR_W-1:0] syn;
    logic             ov_miss;
    logic             syn_nz;
    logic             in_rng;
    logic             do_fix;

    always_comb begin
        cw = '0;
        for (int k = 0; k < DATA_W; k++) cw[data_pos(k)] = data_i[k];
        for (int i = 0; i < PAR_W; i++) cw[1 << i] = chk_i[i];

        syn = '0;
        for (int i = 0; i < PAR_W; i++) begin
            for (int p = 1; p <= CW_W; p++) begin
                if (((p >> i) & 1) == 1) syn[i] = syn[i] ^ cw[p];
            end
        end

        ov_miss = (^cw) ^ chk_i[PAR_W];
        syn_nz  = |syn;
        in_rng  = int'(syn) <= CW_W;
        do_fix  = ov_miss && syn_nz && in_rng;

        for (int p = 1; p <= CW_W; p++)
            cw_fix[p] = cw[p] ^ (do_fix && (int'(syn) == p));
        for (int k = 0; k < DATA_W; k++) data_o[k] = cw_fix[data_pos(k)];

        sef_o = ov_miss && (!syn_nz || in_rng);
        def_o = syn_nz && (!ov_miss || !in_rng);
    end
endmodule

// File: rtl/sec_ded_byte.sv
module sec_ded_byte
    import secded_pkg::*;
#(
    parameter int  DATA_W  = 8,
    parameter bit  REG_OUT = 1'b1,
    localparam int CHK_W   = hm_par_bits(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CHK_W-1:0]  enc_check_o,
    input  logic [DATA_W-1:0] dec_data_i,
    input  logic [CHK_W-1:0]  dec_check_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_sef_o,
    output logic              dec_def_o
);
    typedef struct packed {
        logic [CHK_W-1:0]  chk;
        logic [DATA_W-1:0] data;
        logic              sef;
        logic              def;
    } res_t;

    logic [CHK_W-1:0]  enc_chk;
    logic [DATA_W-1:0] dec_data;
    logic              dec_sef;
    logic              dec_def;
    res_t              res_d;
    res_t              res_q;

    sd_encoder #(.DATA_W(DATA_W)) u_enc (
        .data_i (enc_data_i),
        .chk_o  (enc_chk)
    );

    sd_decoder #(.DATA_W(DATA_W)) u_dec (
        .data_i (dec_data_i),
        .chk_i  (dec_check_i),
        .data_o (dec_data),
        .sef_o  (dec_sef),
        .def_o  (dec_def)
    );

    always_comb begin
        res_d.chk  = enc_chk;
        res_d.data = dec_data;
        res_d.sef  = dec_sef;
        res_d.def  = dec_def;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) res_q <= '0;
                else        res_q <= res_d;
            end
        end else begin : g_comb
            always_comb res_q = res_d;
        end
    endgenerate

    assign enc_check_o = res_q.chk;
    assign dec_data_o  = res_q.data;
    assign dec_sef_o   = res_q.sef;
    assign dec_def_o   = res_q.def;
endmodule

// File: rtl/sd_checker.sv
module sd_checker #(
    parameter int DATA_W = 8,
    parameter int CHK_W  = 5,
    parameter bit LAT    = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] enc_data_i,
    input logic [CHK_W-1:0]  enc_check_o,
    input logic [DATA_W-1:0] dec_data_i,
    input logic [DATA_W-1:0] dec_data_o,
    input logic              dec_sef_o,
    input logic              dec_def_o
);
    logic [DATA_W-1:0] enc_al;
    logic [DATA_W-1:0] dec_al;

    generate
        if (LAT) begin : g_al
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    enc_al <= '0;
                    dec_al <= '0;
                end else begin
                    enc_al <= enc_data_i;
                    dec_al <= dec_data_i;
                end
            end
        end else begin : g_al_c
            assign enc_al = enc_data_i;
            assign dec_al = dec_data_i;
        end
    endgenerate

    // R8
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_sef_o && dec_def_o));

    // R2
    enc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((^enc_al) ^ (^enc_check_o)) == 1'b0);

    // R6
    dbl_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_def_o |-> dec_data_o == dec_al);

    // R3
    clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_sef_o && !dec_def_o) |-> dec_data_o == dec_al);

    // R4
    sgl_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_sef_o |-> $countones(dec_data_o ^ dec_al) <= 1);
endmodule

bind sec_ded_byte sd_checker #(
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W),
    .LAT    (REG_OUT)
) u_sd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enc_data_i  (enc_data_i),
    .enc_check_o (enc_check_o),
    .dec_data_i  (dec_data_i),
    .dec_data_o  (dec_data_o),
    .dec_sef_o   (dec_sef_o),
    .dec_def_o   (dec_def_o)
);

// File: tb/tb_sec_ded_byte.sv
`timescale 1ns/1ps
module tb_sec_ded_byte;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] enc_d = '0;
    logic [7:0] dec_d = '0;
    logic [4:0] dec_c = '0;
    logic [4:0] chk_r, chk_c;
    logic [7:0] dat_r, dat_c;
    logic       sef_r, sef_c, def_r, def_c;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    sec_ded_byte #(.DATA_W(8), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .enc_data_i(enc_d), .enc_check_o(chk_r),
        .dec_data_i(dec_d), .dec_check_i(dec_c), .dec_data_o(dat_r),
        .dec_sef_o(sef_r), .dec_def_o(def_r));

    sec_ded_byte #(.DATA_W(8), .REG_OUT(1'b0)) dut_c (
        .clk(clk), .rst_n(rst_n), .enc_data_i(enc_d), .enc_check_o(chk_c),
        .dec_data_i(dec_d), .dec_check_i(dec_c), .dec_data_o(dat_c),
        .dec_sef_o(sef_c), .dec_def_o(def_c));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] ref_chk(input logic [7:0] d);
        int          pos [8] = '{3, 5, 6, 7, 9, 10, 11, 12};
        logic [12:1] cw = '0;
        logic [4:0]  r = '0;
        for (int k = 0; k < 8; k++) cw[pos[k]] = d[k];
        for (int i = 0; i < 4; i++)
            for (int q = 1; q <= 12; q++)
                if (((q >> i) & 1) == 1) r[i] = r[i] ^ cw[q];
        r[4] = (^d) ^ (^r[3:0]);
        return r;
    endfunction

    // drive both paths, then sample after the registered copy has taken them
    task automatic apply(input logic [7:0] e, input logic [7:0] d, input logic [4:0] c);
        @(negedge clk);
        enc_d = e; dec_d = d; dec_c = c;
        @(posedge clk);
        #1;
    endtask

    task automatic check_dec(input string req, input logic [7:0] ed,
                             input bit es, input bit ef);
        check(dat_r === ed, req, "reg data", dat_r, ed);
        check(dat_c === ed, req, "comb data", dat_c, ed);
        check({sef_r, def_r} === {es, ef}, req, "reg flags", {sef_r, def_r}, {es, ef});
        check({sef_c, def_c} === {es, ef}, req, "comb flags", {sef_c, def_c}, {es, ef});
        // R8
        check(!(sef_r && def_r) && !(sef_c && def_c), "R8", "flag exclusion",
              {sef_r, def_r, sef_c, def_c}, 0);
    endtask

    task automatic t_reset;
        @(posedge clk); #1;
        // R9 reset clears the registered outputs
        check({chk_r, dat_r, sef_r, def_r} === '0, "R9", "reset outputs",
              {chk_r, dat_r, sef_r, def_r}, 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_encode_all;
        for (int v = 0; v < 256; v++) begin
            logic [4:0] e;
            e = ref_chk(8'(v));
            apply(8'(v), 8'(v), e);
            check(chk_r[3:0] === e[3:0] && chk_c[3:0] === e[3:0], "R1",
                  "hamming bits", {chk_r[3:0], chk_c[3:0]}, {e[3:0], e[3:0]});
            check(chk_r[4] === e[4] && chk_c[4] === e[4], "R2", "overall bit",
                  {chk_r[4], chk_c[4]}, {e[4], e[4]});
            check_dec("R3", 8'(v), 1'b0, 1'b0);
        end
    endtask

    task automatic t_single(input logic [7:0] d);
        logic [12:0] w;
        logic [12:0] f;
        w = {ref_chk(d), d};
        for (int b = 0; b < 13; b++) begin
            f = w ^ (13'd1 << b);
            apply(d, f[7:0], f[12:8]);
            if (b == 12) check_dec("R5", d, 1'b1, 1'b0);
            else         check_dec("R4", d, 1'b1, 1'b0);
        end
    endtask

    task automatic t_double(input logic [7:0] d);
        logic [12:0] w;
        logic [12:0] f;
        w = {ref_chk(d), d};
        for (int a = 0; a < 13; a++)
            for (int b = a + 1; b < 13; b++) begin
                f = w ^ (13'd1 << a) ^ (13'd1 << b);
                apply(d, f[7:0], f[12:8]);
                check_dec("R6", f[7:0], 1'b0, 1'b1);
            end
    endtask

    task automatic t_out_of_range(input logic [7:0] d);
        logic [4:0] c;
        c = ref_chk(d);
        // flips at positions 1, 4, 8 -> syndrome 13, odd count
        apply(d, d, c ^ 5'b01101);
        check_dec("R7", d, 1'b0, 1'b1);
        // flips at positions 2, 4, 8 -> syndrome 14
        apply(d, d, c ^ 5'b01110);
        check_dec("R7", d, 1'b0, 1'b1);
    endtask

    task automatic t_latency;
        apply(8'h5a, 8'h5a, ref_chk(8'h5a));
        @(negedge clk);
        enc_d = 8'hc3; dec_d = 8'hc3; dec_c = ref_chk(8'hc3);
        #1;
        // R9 registered copy still holds the previous cycle's result
        check(dat_r === 8'h5a && chk_r === ref_chk(8'h5a), "R9", "reg holds old",
              {chk_r, dat_r}, {ref_chk(8'h5a), 8'h5a});
        check(dat_c === 8'hc3 && chk_c === ref_chk(8'hc3), "R9", "comb follows",
              {chk_c, dat_c}, {ref_chk(8'hc3), 8'hc3});
        @(posedge clk); #1;
        check(dat_r === 8'hc3 && chk_r === ref_chk(8'hc3), "R9", "reg after edge",
              {chk_r, dat_r}, {ref_chk(8'hc3), 8'hc3});
    endtask

    initial begin
        #(200000 * 5);
        check(1'b0, "WD", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_encode_all();
        t_single(8'h00);
        t_single(8'hff);
        t_single(8'ha5);
        t_single(8'h3c);
        t_double(8'h00);
        t_double(8'h96);
        t_double(8'hff);
        t_out_of_range(8'h00);
        t_out_of_range(8'h7e);
        t_latency();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule